// File: doc/BRIEF.md
# CEC Bit Receiver

This block listens to a single open-drain consumer-electronics-control wire and turns its pulse train into bytes. A one-cycle tick enable, nominally at 32768 Hz, is the timebase for all measurements. The wire is first synchronised and then cleaned by a three-sample majority-free glitch filter. After that, the time from each falling edge to the next rising edge (low time) and from each falling edge to the next falling edge (period) is measured in ticks. A start pulse opens a frame. Every following pulse is a data bit whose value is the filtered line level at a programmable sample point. The bit is then validated against the low-time window for that value.

Bits are grouped as ten-bit blocks, sent most significant data bit first: eight data bits, an end-of-message bit, then an acknowledge bit. At the end of each block the byte is presented with a one-cycle strobe. A block whose end-of-message bit is set also closes the frame with a done strobe. Any pulse that falls outside its window aborts the frame with an error strobe, and the receiver goes back to hunting for a start pulse. The first block of a frame is the header. When its low nibble equals the programmed logical address and that address is marked valid, the receiver pulls the wire low during every acknowledge bit of the frame. It does so from the acknowledge bit's falling edge for a programmable number of ticks.

Every limit lives in a small write-only register file and resets to the nearest whole tick count of its nominal value.

Top module: `cec_bit_receiver`

## Requirements
- R1: After reset the wire is released (`drive_low`=0), all strobes are low, and an idle high line produces no strobe.
- R2: A start pulse is accepted only when all three of its times fall inside their inclusive windows: low time 115..128 ticks, high time 20..33 ticks, period 141..154 ticks. A rejected start produces no strobe, and the receiver keeps hunting.
- R3: A data bit's value is the filtered line level when 34 ticks have elapsed since its falling edge. The bit is valid only if its low time lies inside the window for that value: 13..26 ticks for a 1, 43..56 ticks for a 0. Any other low time raises `frame_err`.
- R4: Each block is eight data bits (most significant first), an end-of-message bit and an acknowledge bit. On the acknowledge bit's rising edge, `rx_valid` pulses for one cycle with `rx_byte`, `rx_eom` and `rx_ack`. `rx_ack`=0 means the block was acknowledged.
- R5: A block with `rx_eom`=1 also pulses `frame_done` in the same cycle, and the receiver returns to hunting.
- R6: Inside a frame, a low time of 111 ticks or more raises `frame_err` and returns the receiver to hunting.
- R7: Inside a frame, a bit period under 67 ticks raises `frame_err`. A high time above 92 ticks also raises `frame_err`, which happens when a frame stops without an end-of-message block.
- R8: Register 15 holds the logical address in bits [3:0] and a valid flag in bit 4. When valid is set and the header's bits [3:0] equal the address, `drive_low` asserts at each acknowledge bit's falling edge until 49 ticks have elapsed. Otherwise `drive_low` never asserts.
- R9: Writing `cfg_wdata` with `cfg_we` to `cfg_sel` replaces one limit; the new value takes effect from that point on. The indices are:
  - 0/1: start low min/max
  - 2/3: start high min/max
  - 4/5: start period min/max
  - 6/7: one-bit low min/max
  - 8/9: zero-bit low min/max
  - 10: minimum bit period
  - 11: maximum high time
  - 12: sample point
  - 13: acknowledge length
  - 14: error low
  - 15: logical address
- R10: A low or high excursion of the line lasting fewer than three clock samples is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one cycle per tick |
| line_in | input | 1 | Wire level as seen at the pad, 1 = released |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 4 | Limit register index |
| cfg_wdata | input | TW | Limit register write value |
| drive_low | output | 1 | 1 = pull the wire low (acknowledge) |
| rx_valid | output | 1 | One-cycle block strobe |
| rx_byte | output | 8 | Received data byte |
| rx_eom | output | 1 | End-of-message bit of the block |
| rx_ack | output | 1 | Acknowledge bit level (0 = acknowledged) |
| frame_done | output | 1 | One-cycle frame completion strobe |
| frame_err | output | 1 | One-cycle frame abort strobe |

## Verification
The bench sweeps the first data bit's low time across 8..62 ticks. A receiver with an off-by-one window edge would accept or reject exactly one width too many. A receiver that decides the bit value from the width alone instead of the sample point would still pass, but misreading the window end would flip the byte's top bit. It also sweeps the start low time across both window edges. A receiver that counts ticks from the wrong edge would shift the accepted range. Self-acknowledge is checked with a matching, a mismatching and an invalid address. A receiver that ignored the valid flag would pull the wire. One that let its own drive stretch the low time past the zero-bit window would abort its own frame. Truncated frames, short periods, long error lows, a sub-three-sample glitch and a narrowed window after reprogramming each have a case of their own.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    localparam int CFG_N      = 16;
    localparam int CFG_SEL_W  = $clog2(CFG_N);
    localparam int TIME_N     = CFG_N - 1;
    localparam int BLOCK_BITS = 10;
    localparam int DATA_BITS  = 8;

    typedef enum logic [3:0] {
        CFG_SLO_MIN  = 4'd0,
        CFG_SLO_MAX  = 4'd1,
        CFG_SHI_MIN  = 4'd2,
        CFG_SHI_MAX  = 4'd3,
        CFG_STOT_MIN = 4'd4,
        CFG_STOT_MAX = 4'd5,
        CFG_ONE_MIN  = 4'd6,
        CFG_ONE_MAX  = 4'd7,
        CFG_ZERO_MIN = 4'd8,
        CFG_ZERO_MAX = 4'd9,
        CFG_BIT_MIN  = 4'd10,
        CFG_HIGH_MAX = 4'd11,
        CFG_SAMPLE   = 4'd12,
        CFG_ACK_LEN  = 4'd13,
        CFG_ERR_LOW  = 4'd14,
        CFG_LADDR    = 4'd15
    } cfg_idx_e;

    typedef enum logic [1:0] {
        RX_HUNT       = 2'd0,
        RX_START_HIGH = 2'd1,
        RX_DATA       = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 eom;
        logic                 ack;
    } rx_block_t;

    // Nominal limits in 32768 Hz ticks, rounded to the nearest tick.
    function automatic logic [7:0] cfg_default(input cfg_idx_e idx);
        case (idx)
            CFG_SLO_MIN:  return 8'd115;
            CFG_SLO_MAX:  return 8'd128;
            CFG_SHI_MIN:  return 8'd20;
            CFG_SHI_MAX:  return 8'd33;
            CFG_STOT_MIN: return 8'd141;
            CFG_STOT_MAX: return 8'd154;
            CFG_ONE_MIN:  return 8'd13;
            CFG_ONE_MAX:  return 8'd26;
            CFG_ZERO_MIN: return 8'd43;
            CFG_ZERO_MAX: return 8'd56;
            CFG_BIT_MIN:  return 8'd67;
            CFG_HIGH_MAX: return 8'd92;
            CFG_SAMPLE:   return 8'd34;
            CFG_ACK_LEN:  return 8'd49;
            CFG_ERR_LOW:  return 8'd111;
            default:      return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cec_line_filter.sv
module cec_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_f
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_TAPS-1:0]   hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            line_f <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                line_f <= 1'b1;
            else if (~|hist_q)
                line_f <= 1'b0;
        end
    end
endmodule

// File: rtl/cec_pulse_meter.sv
module cec_pulse_meter #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line_f,
    output logic          fall_ev,
    output logic          rise_ev,
    output logic [TW-1:0] since_fall,
    output logic [TW-1:0] since_rise
);
    localparam logic [TW-1:0] SAT = '1;
    logic prev_q;

    assign fall_ev = prev_q & ~line_f;
    assign rise_ev = ~prev_q & line_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b1;
            since_fall <= SAT;
            since_rise <= SAT;
        end else begin
            prev_q <= line_f;
            if (fall_ev)
                since_fall <= TW'(tick);
            else if (since_fall != SAT)
                since_fall <= since_fall + TW'(tick);
            if (rise_ev)
                since_rise <= TW'(tick);
            else if (since_rise != SAT)
                since_rise <= since_rise + TW'(tick);
        end
    end
endmodule

// File: rtl/cec_rx_cfg_regs.sv
module cec_rx_cfg_regs
    import cec_rx_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [CFG_SEL_W-1:0]       sel,
    input  logic [TW-1:0]              wdata,
    output logic [TIME_N-1:0][TW-1:0]  lim_q,
    output logic [3:0]                 la_addr,
    output logic                       la_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TIME_N; i++)
                lim_q[i] <= TW'(cfg_default(cfg_idx_e'(i)));
            la_addr  <= 4'd0;
            la_valid <= 1'b0;
        end else if (we) begin
            for (int i = 0; i < TIME_N; i++)
                if (sel == CFG_SEL_W'(i))
                    lim_q[i] <= wdata;
            if (sel == CFG_LADDR) begin
                la_addr  <= wdata[3:0];
                la_valid <= wdata[4];
            end
        end
    end
endmodule

// File: rtl/cec_bit_receiver.sv
module cec_bit_receiver
    import cec_rx_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 line_in,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_sel,
    input  logic [TW-1:0]        cfg_wdata,
    output logic                 drive_low,
    output logic                 rx_valid,
    output logic [7:0]           rx_byte,
    output logic                 rx_eom,
    output logic                 rx_ack,
    output logic                 frame_done,
    output logic                 frame_err
);
    logic                      line_f, fall_ev, rise_ev;
    logic [TW-1:0]             since_fall, since_rise;
    logic [TIME_N-1:0][TW-1:0] lim;
    logic [3:0]                la_addr;
    logic                      la_valid;

    cec_line_filter u_filter (.clk(clk), .rst(rst), .line_in(line_in), .line_f(line_f));

    cec_pulse_meter #(.TW(TW)) u_meter (
        .clk(clk), .rst(rst), .tick(tick), .line_f(line_f),
        .fall_ev(fall_ev), .rise_ev(rise_ev),
        .since_fall(since_fall), .since_rise(since_rise));

    cec_rx_cfg_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .lim_q(lim), .la_addr(la_addr), .la_valid(la_valid));

    function automatic logic in_win(input logic [TW-1:0] v, input logic [TW-1:0] lo,
                                    input logic [TW-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    rx_state_e            state_q;
    logic [3:0]           bitpos_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 eom_q, bitval_q, addressed_q, header_q, ack_active_q;
    logic [TW-1:0]        low_q;
    rx_block_t            blk_q;
    logic                 valid_q, done_q, err_q;

    logic [TW-1:0] high_len;
    logic          bit_ok, start_ok, data_fail;

    assign high_len = since_fall - low_q;
    assign bit_ok   = bitval_q ? in_win(since_fall, lim[CFG_ONE_MIN], lim[CFG_ONE_MAX])
                               : in_win(since_fall, lim[CFG_ZERO_MIN], lim[CFG_ZERO_MAX]);
    assign start_ok = in_win(high_len, lim[CFG_SHI_MIN], lim[CFG_SHI_MAX]) &&
                      in_win(since_fall, lim[CFG_STOT_MIN], lim[CFG_STOT_MAX]);
    assign data_fail = (state_q == RX_DATA) &&
                       ((fall_ev && since_fall < lim[CFG_BIT_MIN]) ||
                        (rise_ev && (since_fall >= lim[CFG_ERR_LOW] || !bit_ok)) ||
                        (line_f && !rise_ev && since_rise > lim[CFG_HIGH_MAX]));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= RX_HUNT;
            bitpos_q     <= '0;
            shift_q      <= '0;
            eom_q        <= 1'b0;
            bitval_q     <= 1'b1;
            addressed_q  <= 1'b0;
            header_q     <= 1'b0;
            ack_active_q <= 1'b0;
            low_q        <= '0;
            blk_q        <= '0;
            valid_q      <= 1'b0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            if (ack_active_q && since_fall >= lim[CFG_ACK_LEN])
                ack_active_q <= 1'b0;
            case (state_q)
                RX_HUNT: begin
                    if (rise_ev && in_win(since_fall, lim[CFG_SLO_MIN], lim[CFG_SLO_MAX])) begin
                        low_q   <= since_fall;
                        state_q <= RX_START_HIGH;
                    end
                end
                RX_START_HIGH: begin
                    if (fall_ev) begin
                        if (start_ok) begin
                            state_q     <= RX_DATA;
                            bitpos_q    <= '0;
                            header_q    <= 1'b1;
                            addressed_q <= 1'b0;
                            bitval_q    <= 1'b1;
                        end else begin
                            state_q <= RX_HUNT;
                        end
                    end else if (line_f && since_rise > lim[CFG_SHI_MAX]) begin
                        state_q <= RX_HUNT;
                    end
                end
                RX_DATA: begin
                    if (data_fail) begin
                        err_q        <= 1'b1;
                        ack_active_q <= 1'b0;
                        state_q      <= RX_HUNT;
                    end else if (fall_ev) begin
                        bitval_q <= 1'b1;
                        if (bitpos_q == 4'(BLOCK_BITS - 1) && addressed_q && la_valid)
                            ack_active_q <= 1'b1;
                    end else if (!line_f && since_fall == lim[CFG_SAMPLE]) begin
                        bitval_q <= 1'b0;
                    end else if (rise_ev) begin
                        if (bitpos_q < 4'(DATA_BITS)) begin
                            shift_q <= {shift_q[DATA_BITS-2:0], bitval_q};
                            if (header_q && bitpos_q == 4'(DATA_BITS - 1))
                                addressed_q <= la_valid && ({shift_q[2:0], bitval_q} == la_addr);
                        end else if (bitpos_q == 4'(DATA_BITS)) begin
                            eom_q <= bitval_q;
                        end else begin
                            blk_q    <= '{data: shift_q, eom: eom_q, ack: bitval_q};
                            valid_q  <= 1'b1;
                            header_q <= 1'b0;
                            if (eom_q) begin
                                done_q  <= 1'b1;
                                state_q <= RX_HUNT;
                            end
                        end
                        bitpos_q <= (bitpos_q == 4'(BLOCK_BITS - 1)) ? 4'd0 : bitpos_q + 4'd1;
                    end
                end
                default: state_q <= RX_HUNT;
            endcase
        end
    end

    assign drive_low  = ack_active_q && (since_fall < lim[CFG_ACK_LEN]);
    assign rx_valid   = valid_q;
    assign rx_byte    = blk_q.data;
    assign rx_eom     = blk_q.eom;
    assign rx_ack     = blk_q.ack;
    assign frame_done = done_q;
    assign frame_err  = err_q;
endmodule

// File: rtl/cec_bit_receiver_checker.sv
module cec_bit_receiver_checker (
    input logic clk,
    input logic rst,
    input logic drive_low,
    input logic fall_ev,
    input logic la_valid,
    input logic rx_valid,
    input logic rx_eom,
    input logic frame_done,
    input logic frame_err
);
    p_drive_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> $past(fall_ev && la_valid));

    p_done_with_block_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (rx_valid && rx_eom));

    p_done_err_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(frame_done && frame_err));

    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    p_no_drive_after_err_r8: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !drive_low);
endmodule

bind cec_bit_receiver cec_bit_receiver_checker u_chk (
    .clk(clk), .rst(rst), .drive_low(drive_low), .fall_ev(fall_ev),
    .la_valid(la_valid), .rx_valid(rx_valid), .rx_eom(rx_eom),
    .frame_done(frame_done), .frame_err(frame_err));

// File: tb/cec_bit_receiver_test.sv
module cec_bit_receiver_test;
    logic       clk = 1'b0;
    logic       rst, tick, bench_low, cfg_we;
    logic [3:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       line_in, drive_low, rx_valid, rx_eom, rx_ack, frame_done, frame_err;
    logic [7:0] rx_byte;

    always #5 clk = ~clk;
    assign line_in = !(bench_low || drive_low);

    cec_bit_receiver uut (
        .clk(clk), .rst(rst), .tick(tick), .line_in(line_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .drive_low(drive_low), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_eom(rx_eom), .rx_ack(rx_ack), .frame_done(frame_done), .frame_err(frame_err));

    int checks = 0, errors = 0;
    int nblk, ndone, nerr;
    logic saw_drive, finished = 1'b0;
    logic [7:0] gb [0:7];
    logic       ge [0:7];
    logic       ga [0:7];
    localparam logic [7:0] PAT = 8'h35;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (nblk < 8) begin
                    gb[nblk] = rx_byte; ge[nblk] = rx_eom; ga[nblk] = rx_ack;
                end
                nblk++;
            end
            if (frame_done) ndone++;
            if (frame_err)  nerr++;
            if (drive_low)  saw_drive = 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        nblk = 0; ndone = 0; nerr = 0; saw_drive = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int lo, input int tot);
        bench_low = 1'b1; idle(lo);
        bench_low = 1'b0; idle(tot - lo);
    endtask

    task automatic send_bit(input logic b);
        pulse(b ? 20 : 49, 79);
    endtask

    task automatic send_block(input logic [7:0] d, input logic eom);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(eom);
        send_bit(1'b1);
    endtask

    task automatic wcfg(input int sel, input int val);
        cfg_sel = 4'(sel); cfg_wdata = 8'(val); cfg_we = 1'b1;
        idle(1);
        cfg_we = 1'b0;
        idle(1);
    endtask

    task automatic first_bit_frame(input int w);
        clr();
        pulse(121, 151);
        pulse(w, 79);
        for (int i = 6; i >= 0; i--) send_bit(PAT[i]);
        send_bit(1'b1);
        send_bit(1'b1);
        idle(200);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b1; bench_low = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        clr();
        idle(5);
        rst = 1'b0;
        chk("R1 drive after reset", int'(drive_low), 0);
        chk("R1 valid after reset", int'(rx_valid), 0);
        idle(300);
        chk("R1 idle blocks", nblk, 0);
        chk("R1 idle errors", nerr, 0);

        // R8: addressed three-block frame, address 4 valid
        wcfg(15, 'h14);
        clr();
        pulse(121, 151);
        send_block(8'h14, 1'b0);
        send_block(8'h36, 1'b0);
        send_block(8'h81, 1'b1);
        idle(200);
        chk("R4 block count", nblk, 3);
        chk("R4 byte0", int'(gb[0]), 'h14);
        chk("R4 byte1", int'(gb[1]), 'h36);
        chk("R4 byte2", int'(gb[2]), 'h81);
        chk("R4 eom pattern", int'({ge[0], ge[1], ge[2]}), 1);
        chk("R8 acked blocks", int'({ga[0], ga[1], ga[2]}), 0);
        chk("R8 drive seen", int'(saw_drive), 1);
        chk("R5 frame done", ndone, 1);
        chk("R5 no error", nerr, 0);

        // R8: other destination
        clr();
        pulse(121, 151);
        send_block(8'h25, 1'b0);
        send_block(8'hA5, 1'b1);
        idle(200);
        chk("R8 unaddressed blocks", nblk, 2);
        chk("R8 unaddressed byte1", int'(gb[1]), 'hA5);
        chk("R8 unaddressed acks", int'({ga[0], ga[1]}), 3);
        chk("R8 unaddressed drive", int'(saw_drive), 0);

        // R8: matching address but valid flag clear
        wcfg(15, 'h04);
        clr();
        pulse(121, 151);
        send_block(8'h04, 1'b1);
        idle(200);
        chk("R8 invalid-address ack", int'(ga[0]), 1);
        chk("R8 invalid-address drive", int'(saw_drive), 0);

        // R10: two-sample glitch inside start high
        clr();
        bench_low = 1'b1; idle(121);
        bench_low = 1'b0; idle(10);
        bench_low = 1'b1; idle(2);
        bench_low = 1'b0; idle(18);
        send_block(8'h5A, 1'b1);
        idle(200);
        chk("R10 glitch blocks", nblk, 1);
        chk("R10 glitch byte", int'(gb[0]), 'h5A);
        chk("R10 glitch errors", nerr, 0);

        // R2: start low sweep with 26-tick high
        for (int lo = 110; lo <= 131; lo++) begin
            clr();
            pulse(lo, lo + 26);
            send_block(8'h33, 1'b1);
            idle(200);
            chk($sformatf("R2 start low %0d blocks", lo), nblk,
                (lo >= 115 && lo <= 128) ? 1 : 0);
            chk($sformatf("R2 start low %0d errors", lo), nerr, 0);
        end
        clr();
        pulse(121, 160);
        send_block(8'h33, 1'b1);
        idle(200);
        chk("R2 long start high", nblk, 0);

        // R3: first data bit low-time sweep
        for (int w = 8; w <= 62; w++) begin
            logic acc;
            acc = (w >= 13 && w <= 26) || (w >= 43 && w <= 56);
            first_bit_frame(w);
            chk($sformatf("R3 width %0d errors", w), nerr, acc ? 0 : 1);
            if (acc)
                chk($sformatf("R3 width %0d byte", w), int'(gb[0]),
                    int'({(w <= 26) ? 1'b1 : 1'b0, PAT[6:0]}));
            else
                chk($sformatf("R3 width %0d blocks", w), nblk, 0);
        end

        // R6: long low mid-frame
        clr();
        pulse(121, 151);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pulse(115, 145);
        idle(200);
        chk("R6 error low", nerr, 1);
        chk("R6 no block", nblk, 0);

        // R7: short bit period
        clr();
        pulse(121, 151);
        pulse(20, 50);
        send_bit(1'b1);
        idle(200);
        chk("R7 short period", nerr, 1);

        // R7: frame stops after a non-final block
        clr();
        pulse(121, 151);
        send_block(8'h5C, 1'b0);
        idle(300);
        chk("R7 truncated blocks", nblk, 1);
        chk("R7 truncated error", nerr, 1);
        chk("R7 truncated done", ndone, 0);

        // R9: narrow the one-bit window
        wcfg(7, 20);
        first_bit_frame(24);
        chk("R9 narrowed window rejects", nerr, 1);
        first_bit_frame(18);
        chk("R9 narrowed window accepts", int'(gb[0]), 'hB5);
        wcfg(7, 26);
        first_bit_frame(24);
        chk("R9 restored window", nerr, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule